// File: doc/BRIEF.md
# Three-Channel Terminal-Count Interval Timer

This block holds three independent 16-bit down-counters behind a small byte-wide register interface. Each counter is programmed with an 8-bit control word that picks the counter, the byte access pattern and the counting format. The starting count is then loaded one or two bytes at a time. Once loaded, a counter steps down by one on every count pulse that arrives while its gate is high. Its output level goes high when the count reaches zero, which makes the block suited to inactivity time-outs: software reloads the counter while traffic is seen, and an external interrupt path watches the output.

Only the interrupt-on-terminal-count behaviour is built. A control word that asks for any other mode leaves that counter idle and raises a per-counter flag. Counting can be plain 16-bit binary or four BCD decades. A latch command freezes a copy of the count for a consistent read-back while the live counter keeps running. Count pulses are single-cycle enables in the system clock domain. How those pulses are produced, and where the outputs are routed, is left to the surrounding logic.

Top module: `countdown_timer_unit`

## Requirements
- R1: Control word bits 7:6 pick counter 0, 1 or 2. The value 3 addresses no counter, and such a word changes no counter's count, output or access state.
- R2: Control word bits 3:1 must be 000. Any other value sets that counter's `bad_mode` bit, stops it, and makes it ignore data writes until a control word with mode 000 clears the flag.
- R3: One cycle after a control word with mode 000 and bits 5:4 not equal to 00, the counter's output is low. It stays low until a decrement produces zero. Wrapping from zero does not raise it.
- R4: When a decrement produces a count of zero, the output goes high. It stays high while counting carries on and wraps, and drops only on the next control word or data load.
- R5: With access bits 5:4 = 10, a data write loads the low byte and clears the high byte, and reads return the low byte. With 01, a data write loads the high byte and clears the low byte, and reads return the high byte.
- R6: With access bits 5:4 = 11, writes go low byte first and then high byte. The counter does not count between the two writes. Reads alternate in the same order, starting from the low byte after the control word.
- R7: A loaded counter steps down by exactly one on each clock cycle where its `tick` bit and its `gate` bit are both high. Its count holds while the gate is low.
- R8: Control word bit 0 = 1 selects four-decade BCD counting, in which 0000 steps to 9999. Bit 0 = 0 selects binary counting, in which 0000 steps to FFFF.
- R9: A control word with bits 5:4 = 00 takes a snapshot of that counter's count. Reads return the snapshot, over one read (or two reads for access 11), while the live count keeps moving. After that, reads follow the live count again.
- R10: After reset all outputs and `bad_mode` bits are low and all counts read as zero.
- R11: Address 0, 1 and 2 select the data port of counter 0, 1 and 2. Address 3 is the control word (write only). A read at address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe (advances the read byte order) |
| addr | input | 2 | Register select: 0 to 2 counter data, 3 control word |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for the addressed counter |
| tick | input | 3 | Per-counter single-cycle count pulse |
| gate | input | 3 | Per-counter count enable level |
| out | output | 3 | Per-counter terminal-count output level |
| bad_mode | output | 3 | Per-counter unsupported-mode flag |

## Verification
On every cycle, the bound checker confirms four things. A valid control word drives its counter's output low on the next cycle, and an unsupported mode raises the flag. A high output survives any cycle without a write. A counter whose gate is low and which is not being loaded keeps its count. Only the bench's scenarios can show that the counted values are right. These cover BCD and binary wrap, the byte order of split loads and reads, snapshot contents set against the live count, and rejected words that leave state untouched. Each of these depends on a sequence of bus accesses, not on a single-cycle relation.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = 2 * BYTE_W;
   localparam int DIGITS = CNT_W / 4;
   localparam logic [1:0] ADDR_CTRL = 2'd3;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'b00,
      ACC_HI    = 2'b01,
      ACC_LO    = 2'b10,
      ACC_BOTH  = 2'b11
   } acc_e;
endpackage

// File: rtl/cdt_dec.sv
// Next-lower count value, in binary or in four BCD decades.
module cdt_dec
   import cdt_pkg::*;
(
   input  logic [CNT_W-1:0] value,
   input  logic             bcd,
   output logic [CNT_W-1:0] result
);
   logic [DIGITS:0]   borrow;
   logic [CNT_W-1:0]  bcd_val;

   assign borrow[0] = 1'b1;

   // Borrow ripple across decades: a zero digit under borrow becomes 9.
   for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      logic [3:0] dig;
      assign dig = value[4*d +: 4];
      assign bcd_val[4*d +: 4] = !borrow[d] ? dig :
                                 (dig == 4'd0) ? 4'd9 : dig - 4'd1;
      assign borrow[d+1] = borrow[d] & (dig == 4'd0);
   end

   assign result = bcd ? bcd_val : value - CNT_W'(1);
endmodule

// File: rtl/cdt_channel.sv
// One counter: control state, byte sequencing, snapshot and counting.
module cdt_channel
   import cdt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [5:0]        ctrl_field,
   input  logic              data_wr,
   input  logic              rd_stb,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              tick,
   input  logic              gate,
   output logic              out,
   output logic              bad_mode,
   output logic [BYTE_W-1:0] rd_byte,
   output logic [CNT_W-1:0]  count
);
   acc_e              acc_q;
   logic              bcd_q, bad_q, armed_q, out_q;
   logic              wr_ptr_q, rd_ptr_q, latched_q;
   logic [BYTE_W-1:0] hold_q;
   logic [CNT_W-1:0]  cnt_q, snap_q, dec_val;
   logic              last_byte, hi_sel;
   logic [CNT_W-1:0]  rd_src;

   cdt_dec u_dec (.value(cnt_q), .bcd(bcd_q), .result(dec_val));

   assign last_byte = (acc_q != ACC_BOTH) || rd_ptr_q;
   assign hi_sel    = (acc_q == ACC_HI) || ((acc_q == ACC_BOTH) && rd_ptr_q);
   assign rd_src    = latched_q ? snap_q : cnt_q;
   assign rd_byte   = hi_sel ? rd_src[CNT_W-1 -: BYTE_W] : rd_src[BYTE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= ACC_LATCH;
         bcd_q     <= 1'b0;
         bad_q     <= 1'b0;
         armed_q   <= 1'b0;
         out_q     <= 1'b0;
         wr_ptr_q  <= 1'b0;
         rd_ptr_q  <= 1'b0;
         latched_q <= 1'b0;
         hold_q    <= '0;
         cnt_q     <= '0;
         snap_q    <= '0;
      end else begin
         if (ctrl_wr) begin
            if (acc_e'(ctrl_field[5:4]) == ACC_LATCH) begin
               if (!latched_q) begin
                  snap_q    <= cnt_q;
                  latched_q <= 1'b1;
               end
            end else begin
               acc_q     <= acc_e'(ctrl_field[5:4]);
               bcd_q     <= ctrl_field[0];
               bad_q     <= (ctrl_field[3:1] != 3'b000);
               armed_q   <= 1'b0;
               out_q     <= 1'b0;
               wr_ptr_q  <= 1'b0;
               rd_ptr_q  <= 1'b0;
               latched_q <= 1'b0;
            end
         end else if (data_wr && !bad_q && (acc_q != ACC_LATCH)) begin
            out_q <= 1'b0;
            unique case (acc_q)
               ACC_HI: begin
                  cnt_q   <= {wdata, {BYTE_W{1'b0}}};
                  armed_q <= 1'b1;
               end
               ACC_LO: begin
                  cnt_q   <= {{BYTE_W{1'b0}}, wdata};
                  armed_q <= 1'b1;
               end
               default: begin
                  if (!wr_ptr_q) begin
                     hold_q   <= wdata;
                     wr_ptr_q <= 1'b1;
                     armed_q  <= 1'b0;
                  end else begin
                     cnt_q    <= {wdata, hold_q};
                     wr_ptr_q <= 1'b0;
                     armed_q  <= 1'b1;
                  end
               end
            endcase
         end else if (armed_q && gate && tick) begin
            cnt_q <= dec_val;
            if (dec_val == '0) out_q <= 1'b1;
         end

         if (rd_stb && !ctrl_wr) begin
            if (acc_q == ACC_BOTH) rd_ptr_q <= !rd_ptr_q;
            if (latched_q && last_byte) latched_q <= 1'b0;
         end
      end
   end

   assign out      = out_q;
   assign bad_mode = bad_q;
   assign count    = cnt_q;
endmodule

// File: rtl/countdown_timer_unit.sv
module countdown_timer_unit
   import cdt_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   input  logic [NUM_CH-1:0] tick,
   input  logic [NUM_CH-1:0] gate,
   output logic [NUM_CH-1:0] out,
   output logic [NUM_CH-1:0] bad_mode
);
   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_param
      $error("NUM_CH must lie between 1 and 3");
   end

   logic [BYTE_W-1:0]       rd_bytes [NUM_CH];
   logic [NUM_CH*CNT_W-1:0] cnt_flat;
   logic                    ctrl_sel;

   assign ctrl_sel = wr_en && (addr == ADDR_CTRL);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit_ctrl, hit_data, hit_rd;
      assign hit_ctrl = ctrl_sel && (wdata[7:6] == 2'(i));
      assign hit_data = wr_en && (addr == 2'(i));
      assign hit_rd   = rd_en && (addr == 2'(i));

      cdt_channel u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .ctrl_wr   (hit_ctrl),
         .ctrl_field(wdata[5:0]),
         .data_wr   (hit_data),
         .rd_stb    (hit_rd),
         .wdata     (wdata),
         .tick      (tick[i]),
         .gate      (gate[i]),
         .out       (out[i]),
         .bad_mode  (bad_mode[i]),
         .rd_byte   (rd_bytes[i]),
         .count     (cnt_flat[i*CNT_W +: CNT_W])
      );
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr == 2'(i)) rdata = rd_bytes[i];
      end
   end
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker
   import cdt_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic [1:0]              addr,
   input logic [BYTE_W-1:0]       wdata,
   input logic [BYTE_W-1:0]       rdata,
   input logic [NUM_CH-1:0]       gate,
   input logic [NUM_CH-1:0]       out,
   input logic [NUM_CH-1:0]       bad_mode,
   input logic [NUM_CH*CNT_W-1:0] cnt_flat
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      logic ctrl_hit;
      assign ctrl_hit = wr_en && (addr == ADDR_CTRL) && (wdata[7:6] == 2'(i))
                        && (wdata[5:4] != 2'b00);

      assert_out_low_on_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_hit && (wdata[3:1] == 3'b000)) |=> !out[i]);

      assert_flag_bad_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_hit && (wdata[3:1] != 3'b000)) |=> bad_mode[i]);

      assert_out_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (out[i] && !wr_en) |=> out[i]);

      assert_hold_gate_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!gate[i] && !(wr_en && (addr == 2'(i)))) |=> $stable(cnt_flat[i*CNT_W +: CNT_W]));
   end

   assert_ctrl_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_CTRL) |-> (rdata == '0));
endmodule

bind countdown_timer_unit cdt_checker #(.NUM_CH(NUM_CH)) u_cdt_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .rdata   (rdata),
   .gate    (gate),
   .out     (out),
   .bad_mode(bad_mode),
   .cnt_flat(cnt_flat)
);

// File: tb/test_countdown_timer_unit.sv
module test_countdown_timer_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [2:0] tick = 3'b000, gate = 3'b111;
   logic [2:0] out, bad_mode;
   int         total = 0, bad = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   countdown_timer_unit i_countdown_timer_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tick(tick), .gate(gate), .out(out),
      .bad_mode(bad_mode)
   );

   // {req[23:20], op[19:18], addr[17:16], data[15:8], exp[7:0]}
   // op: 0 write, 1 read and compare, 2 ticks {mask[7:5], n[4:0]}, 3 compare out
   localparam int NV = 38;
   localparam logic [23:0] VEC [NV] = '{
      24'h3_3_30_00, // R3 ch0 access 11, binary
      24'h3_C_00_00, // R3 out low
      24'h6_0_05_00, // R6 low byte
      24'h6_0_00_00, // R6 high byte
      24'h7_8_24_00, // R7 four ticks on ch0
      24'h6_4_00_01, // R6 read low
      24'h6_4_00_00, // R6 read high
      24'h3_C_00_00, // R3 still low at count 1
      24'h4_8_21_00, // R4 last tick
      24'h4_C_00_01, // R4 out high
      24'h4_4_00_00,
      24'h4_4_00_00,
      24'h8_3_61_00, // R8 ch1 access 10, BCD
      24'h5_1_10_00, // R5 low only
      24'h8_8_41_00,
      24'h8_5_00_09, // R8 BCD 0010 -> 0009
      24'h5_3_90_00, // R5 ch2 access 01
      24'h5_2_02_00, // R5 high only -> 0200
      24'h8_8_81_00,
      24'h5_6_00_01, // R5 01FF reads high byte
      24'h3_3_30_00, // R3 reprogram ch0
      24'h3_C_00_00, // R3 out dropped
      24'h6_0_34_00,
      24'h6_0_12_00,
      24'h9_3_00_00, // R9 latch ch0 at 1234
      24'h9_8_22_00, // R9 live count moves to 1232
      24'h9_4_00_34,
      24'h9_4_00_12,
      24'h9_4_00_32, // R9 live again
      24'h9_4_00_12,
      24'h1_3_F0_00, // R1 select 3 is ignored
      24'h1_4_00_32,
      24'h1_4_00_12,
      24'h1_C_00_00,
      24'h2_3_62_00, // R2 ch1 mode 1 rejected
      24'h2_1_55_00, // R2 data ignored
      24'h2_8_43_00, // R2 no counting
      24'h2_5_00_09
   };

   task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input int req, input logic [1:0] a, input logic [7:0] exp);
      @(negedge clk); addr = a; rd_en = 1'b1;
      #1 check(req, rdata, exp);
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic ticks(input logic [2:0] mask, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick = mask;
         @(negedge clk); tick = 3'b000;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(10, {5'd0, out}, 8'h00);
      check(10, {5'd0, bad_mode}, 8'h00);
      rd(10, 2'd0, 8'h00);

      for (int v = 0; v < NV; v++) begin
         logic [3:0] rq; logic [1:0] op, a; logic [7:0] d, e;
         {rq, op, a, d, e} = VEC[v];
         case (op)
            2'd0: wr(a, d);
            2'd1: rd(int'(rq), a, e);
            2'd2: ticks(d[7:5], int'(d[4:0]));
            default: begin @(negedge clk); check(int'(rq), {5'd0, out}, e); end
         endcase
      end

      // R2 flag visible, then cleared by a valid word
      check(2, {5'd0, bad_mode}, 8'h02);
      // R11 control address reads zero
      rd(11, 2'd3, 8'h00);
      // R8 BCD wrap 0000 -> 9999
      wr(2'd3, 8'h61);
      @(negedge clk); check(2, {7'd0, bad_mode[1]}, 8'h00);
      wr(2'd1, 8'h00); ticks(3'b010, 1); rd(8, 2'd1, 8'h99);
      // R8 binary wrap 0000 -> FFFF, R3 output stays low
      wr(2'd3, 8'h20); wr(2'd0, 8'h00); ticks(3'b001, 1);
      rd(8, 2'd0, 8'hFF);
      @(negedge clk); check(3, {7'd0, out[0]}, 8'h00);
      // R6 no counting between the two load bytes
      wr(2'd3, 8'h30); wr(2'd0, 8'h05); ticks(3'b001, 2); wr(2'd0, 8'h00);
      rd(6, 2'd0, 8'h05); rd(6, 2'd0, 8'h00);
      // R7 gate low holds the count
      wr(2'd3, 8'h90); wr(2'd2, 8'h03);
      gate = 3'b011; ticks(3'b100, 3); rd(7, 2'd2, 8'h03);
      gate = 3'b111; ticks(3'b100, 1); rd(7, 2'd2, 8'h02);
      // R4 output stays high past zero
      wr(2'd3, 8'hA0); wr(2'd2, 8'h01); ticks(3'b100, 1);
      @(negedge clk); check(4, {7'd0, out[2]}, 8'h01);
      ticks(3'b100, 1);
      @(negedge clk); check(4, {7'd0, out[2]}, 8'h01);
      rd(4, 2'd2, 8'hFF);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule